// File: doc/BRIEF.md
# Match-Compare System Timer with Watchdog Reset

This block holds a free-running 32-bit up-counter that advances by one on each clock cycle where the external `tick` strobe is high. The strobe typically comes from a prescaler outside the block. Four match registers sit beside the counter. When `tick` is high and the counter equals a channel's match value, and that channel's interrupt enable bit is set, the channel's pending bit is set. Each channel has its own interrupt line, which stays high while the bit is pending. Software clears pending bits by writing ones to the status register.

Channel 3 can also act as a watchdog. Once software sets the watchdog enable, a channel-3 match produces a one-cycle system reset pulse. Software can load the counter at any time, and counting resumes from the loaded value.

All registers sit on a simple single-cycle register bus. A write takes effect on the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`.

Top module: `ost_timer`

## Requirements
- R1: After a synchronous reset, the counter, all match values, the status bits, the enable register and the watchdog enable read as zero, and `irq` and `wdt_reset` are low.
- R2: On each cycle with `tick` high and no counter write, the counter increases by one and wraps from 0xFFFFFFFF to 0. With `tick` low it holds its value.
- R3: A write to offset 0x10 loads the counter with the written value, taking priority over `tick` in that cycle. A read of 0x10 returns the live count.
- R4: Match values for channels 0, 1, 2 and 3 are written and read at offsets 0x00, 0x04, 0x08 and 0x0C.
- R5: If `tick` is high, the counter equals match value i and enable bit i (bit i of offset 0x1C) is set, then status bit i (bit i of offset 0x14) is set on the next cycle. `irq[i]` is high exactly while status bit i is set.
- R6: A match on a channel whose enable bit is clear leaves that channel's status bit and `irq` line unchanged.
- R7: Writing offset 0x14 clears each status bit whose written bit is 1 and leaves the others alone. A match that sets a bit in the same cycle wins over the clear.
- R8: Offset 0x1C keeps only the low 12 written bits. A read returns them with the upper 20 bits zero.
- R9: Writing a 1 to bit 0 of offset 0x18 sets the watchdog enable. Writing 0 does not clear it; only reset does. A read returns the enable in bit 0.
- R10: While the watchdog enable is set, a channel-3 match pulses `wdt_reset` high for exactly the next cycle, whether or not enable bit 3 is set. Without the watchdog enable, `wdt_reset` stays low.
- R11: Reads of any offset other than 0x00–0x1C in word steps return zero, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count strobe from the external prescaler |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq | output | 4 | One interrupt line per match channel |
| wdt_reset | output | 1 | One-cycle watchdog reset pulse |

## Verification
A wrong count shows immediately on a read of offset 0x10, and it also moves every later match one or more ticks away from the expected cycle. A bad compare or a bad enable gate appears as a status bit or an `irq` line that differs one cycle after the tick that hit the match value. A wrongly cleared or wrongly kept pending bit shows at the next status read. A faulty watchdog latch shows either as a missing pulse or as a reset pulse after a write of zero to the enable, one cycle after the channel-3 match.

// File: rtl/ost_pkg.sv
package ost_pkg;
    localparam int CNT_W  = 32;
    localparam int NCH    = 4;
    localparam int EN_W   = 12;
    localparam int ADDR_W = 8;
    localparam int WD_CH  = NCH - 1;

    localparam logic [ADDR_W-1:0] A_COUNT = 8'h10;
    localparam logic [ADDR_W-1:0] A_STAT  = 8'h14;
    localparam logic [ADDR_W-1:0] A_WDOG  = 8'h18;
    localparam logic [ADDR_W-1:0] A_IEN   = 8'h1C;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_MATCH, SEL_COUNT, SEL_STAT, SEL_WDOG, SEL_IEN
    } sel_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  data;
    } bus_req_t;

    function automatic sel_e decode(input logic [ADDR_W-1:0] a);
        if (a[ADDR_W-1:4] == '0 && a[1:0] == 2'b00) return SEL_MATCH;
        case (a)
            A_COUNT: return SEL_COUNT;
            A_STAT:  return SEL_STAT;
            A_WDOG:  return SEL_WDOG;
            A_IEN:   return SEL_IEN;
            default: return SEL_NONE;
        endcase
    endfunction

    function automatic logic [1:0] chan_of(input logic [ADDR_W-1:0] a);
        return a[3:2];
    endfunction
endpackage

// File: rtl/ost_counter.sv
module ost_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (load) cnt <= load_val;
        else if (tick) cnt <= cnt + 1'b1;
    end

    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && !load) |=> cnt == $past(cnt) + 1'b1);
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(cnt));
    assert_load_R3: assert property (@(posedge clk) disable iff (rst)
        load |=> cnt == $past(load_val));
endmodule

// File: rtl/ost_match.sv
module ost_match #(
    parameter int W = 32,
    parameter int N = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic [W-1:0]        cnt,
    input  logic [N-1:0][W-1:0] match_vals,
    input  logic [N-1:0]        en,
    input  logic [N-1:0]        clr,
    output logic [N-1:0]        hit,
    output logic [N-1:0]        stat
);
    for (genvar i = 0; i < N; i++) begin : g_ch
        assign hit[i] = tick && (cnt == match_vals[i]);

        always_ff @(posedge clk) begin
            if (rst)                  stat[i] <= 1'b0;
            else if (hit[i] && en[i]) stat[i] <= 1'b1;
            else if (clr[i])          stat[i] <= 1'b0;
        end

        assert_set_R5: assert property (@(posedge clk) disable iff (rst)
            (hit[i] && en[i]) |=> stat[i]);
        assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
            (clr[i] && !(hit[i] && en[i])) |=> !stat[i]);
        assert_gate_R6: assert property (@(posedge clk) disable iff (rst)
            (!stat[i] && !en[i]) |=> !stat[i]);
    end
endmodule

// File: rtl/ost_timer.sv
module ost_timer
    import ost_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [NCH-1:0]    irq,
    output logic              wdt_reset
);
    bus_req_t                  req;
    sel_e                      sel;
    logic [CNT_W-1:0]          cnt;
    logic [NCH-1:0][CNT_W-1:0] match_q;
    logic [EN_W-1:0]           ien_q;
    logic                      wdog_q;
    logic                      wrst_q;
    logic [NCH-1:0]            hit;
    logic [NCH-1:0]            stat;
    logic [NCH-1:0]            clr;
    logic                      cnt_load;

    assign req      = '{wr: bus_wr, addr: bus_addr, data: bus_wdata};
    assign sel      = decode(req.addr);
    assign cnt_load = req.wr && sel == SEL_COUNT;
    assign clr      = (req.wr && sel == SEL_STAT) ? req.data[NCH-1:0] : '0;

    ost_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick),
        .load(cnt_load), .load_val(req.data), .cnt(cnt)
    );

    ost_match #(.W(CNT_W), .N(NCH)) u_match (
        .clk(clk), .rst(rst), .tick(tick), .cnt(cnt),
        .match_vals(match_q), .en(ien_q[NCH-1:0]), .clr(clr),
        .hit(hit), .stat(stat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            match_q <= '0;
            ien_q   <= '0;
            wdog_q  <= 1'b0;
            wrst_q  <= 1'b0;
        end else begin
            wrst_q <= wdog_q && hit[WD_CH];
            if (req.wr) begin
                for (int i = 0; i < NCH; i++)
                    if (sel == SEL_MATCH && chan_of(req.addr) == 2'(i))
                        match_q[i] <= req.data;
                if (sel == SEL_IEN)  ien_q <= req.data[EN_W-1:0];
                if (sel == SEL_WDOG && req.data[0]) wdog_q <= 1'b1;
            end
        end
    end

    always_comb begin
        case (sel)
            SEL_MATCH: bus_rdata = match_q[chan_of(req.addr)];
            SEL_COUNT: bus_rdata = cnt;
            SEL_STAT:  bus_rdata = {{(CNT_W-NCH){1'b0}}, stat};
            SEL_WDOG:  bus_rdata = {{(CNT_W-1){1'b0}}, wdog_q};
            SEL_IEN:   bus_rdata = {{(CNT_W-EN_W){1'b0}}, ien_q};
            default:   bus_rdata = '0;
        endcase
    end

    assign irq       = stat;
    assign wdt_reset = wrst_q;

    assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        wdog_q |=> wdog_q);
    assert_nowdog_R10: assert property (@(posedge clk) disable iff (rst)
        !wdog_q |=> !wdt_reset);
    assert_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        (wdog_q && hit[WD_CH]) |=> wdt_reset);
endmodule

// File: tb/sim_ost_timer.sv
module sim_ost_timer;
    localparam int PERIOD = 10;
    localparam int NTAB   = 7;
    localparam logic [7:0]  T_ADDR [NTAB] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h1C, 8'h20, 8'hFC};
    localparam logic [31:0] T_DATA [NTAB] = '{32'h1111_1111, 32'h2222_2222, 32'h3333_3333,
                                             32'h4444_4444, 32'hFFFF_F00A, 32'hDEAD_BEEF, 32'h1234_5678};
    localparam logic [31:0] T_EXP  [NTAB] = '{32'h1111_1111, 32'h2222_2222, 32'h3333_3333,
                                             32'h4444_4444, 32'h0000_000A, 32'h0, 32'h0};
    // requirement per row: R4 x4, R8, R11 x2
    localparam int T_REQ [NTAB] = '{4, 4, 4, 4, 8, 11, 11};

    logic        clk = 0, rst = 1, tick = 0, wr = 0;
    logic [7:0]  addr = 0;
    logic [31:0] wdata = 0, rdata, rv;
    logic [3:0]  irq;
    logic        wdt_reset;
    int n_cmp = 0, n_bad = 0;

    always #(PERIOD/2) clk = ~clk;

    ost_timer u0 (.clk(clk), .rst(rst), .tick(tick), .bus_wr(wr), .bus_addr(addr),
                  .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq), .wdt_reset(wdt_reset));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); wr = 1; addr = a; wdata = d;
        @(posedge clk); @(negedge clk); wr = 0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; #1; d = rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk); tick = 1;
        repeat (n) @(posedge clk);
        @(negedge clk); tick = 0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++; n_cmp++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R1 reset state
        rd_reg(8'h10, rv); check("R1 counter", rv, 0);
        rd_reg(8'h14, rv); check("R1 status", rv, 0);
        rd_reg(8'h1C, rv); check("R1 enable", rv, 0);
        rd_reg(8'h18, rv); check("R1 watchdog", rv, 0);
        rd_reg(8'h08, rv); check("R1 match2", rv, 0);
        check("R1 irq", {28'h0, irq}, 0);
        check("R1 wdt_reset", {31'h0, wdt_reset}, 0);

        // table: R4 match regs, R8 enable width, R11 unmapped
        for (int k = 0; k < NTAB; k++) begin
            wr_reg(T_ADDR[k], T_DATA[k]);
            rd_reg(T_ADDR[k], rv);
            check($sformatf("R%0d table row %0d", T_REQ[k], k), rv, T_EXP[k]);
        end

        // R3 load, R2 count and hold
        wr_reg(8'h10, 32'd100);
        rd_reg(8'h10, rv); check("R3 load", rv, 100);
        ticks(5);
        rd_reg(8'h10, rv); check("R2 count", rv, 105);
        repeat (3) @(posedge clk);
        rd_reg(8'h10, rv); check("R2 hold", rv, 105);
        wr_reg(8'h10, 32'hFFFF_FFFF);
        ticks(1);
        rd_reg(8'h10, rv); check("R2 wrap", rv, 0);

        // R5 enabled match on channel 1 (enable = 0x00A: ch1, ch3)
        wr_reg(8'h04, 32'd200);
        wr_reg(8'h10, 32'd198);
        ticks(2);
        check("R5 no early match", {28'h0, irq}, 0);
        ticks(1);
        rd_reg(8'h14, rv); check("R5 status", rv, 32'h2);
        check("R5 irq", {28'h0, irq}, 4'b0010);
        rd_reg(8'h10, rv); check("R3 continues after load", rv, 201);

        // R6 disabled channel 0
        wr_reg(8'h00, 32'd300);
        wr_reg(8'h10, 32'd299);
        ticks(2);
        rd_reg(8'h14, rv); check("R6 disabled status", rv, 32'h2);
        check("R6 disabled irq", {28'h0, irq}, 4'b0010);

        // R7 write-one-to-clear
        wr_reg(8'h14, 32'hD);
        rd_reg(8'h14, rv); check("R7 zero bits keep", rv, 32'h2);
        wr_reg(8'h14, 32'h2);
        rd_reg(8'h14, rv); check("R7 clear", rv, 0);
        check("R7 irq drop", {28'h0, irq}, 0);
        wr_reg(8'h10, 32'd200);
        @(negedge clk); tick = 1; wr = 1; addr = 8'h14; wdata = 32'h2;
        @(posedge clk); @(negedge clk); tick = 0; wr = 0;
        rd_reg(8'h14, rv); check("R7 set wins", rv, 32'h2);
        wr_reg(8'h14, 32'hF);

        // R10 no watchdog: channel 3 match gives interrupt only
        wr_reg(8'h0C, 32'd500);
        wr_reg(8'h10, 32'd500);
        ticks(1);
        check("R10 no pulse when off", {31'h0, wdt_reset}, 0);
        check("R5 irq ch3", {28'h0, irq}, 4'b1000);
        wr_reg(8'h14, 32'h8);

        // R9 sticky enable
        wr_reg(8'h18, 32'h1);
        rd_reg(8'h18, rv); check("R9 set", rv, 1);
        wr_reg(8'h18, 32'h0);
        rd_reg(8'h18, rv); check("R9 sticky", rv, 1);

        // R10 pulse with enable bit 3 cleared
        wr_reg(8'h1C, 32'h002);
        wr_reg(8'h10, 32'd500);
        ticks(1);
        check("R10 pulse", {31'h0, wdt_reset}, 1);
        check("R6 ch3 disabled irq", {28'h0, irq}, 0);
        @(negedge clk);
        check("R10 one cycle", {31'h0, wdt_reset}, 0);

        // R11 write to unmapped changed nothing
        rd_reg(8'h00, rv); check("R11 match0 intact", rv, 300);

        // R9 only reset clears the enable
        @(negedge clk); rst = 1;
        @(posedge clk); @(negedge clk); rst = 0;
        rd_reg(8'h18, rv); check("R9 reset clears", rv, 0);
        rd_reg(8'h1C, rv); check("R1 enable after reset", rv, 0);

        finish_run();
    end
endmodule